// File: doc/BRIEF.md
# Address Range Access Gate

The range gate sits between a single bus master and a set of downstream slave regions. Every transfer from the master is checked against a table of eight address windows, each fixed at build time by a base and a size parameter. Each window also has a software kill bit. A transfer is sent on to the slave side only when its address falls inside at least one window whose kill bit is clear. Otherwise the gate answers the master itself with an error response and read data of zero, and raises a one-cycle fault pulse toward the processor.

A small register port holds the kill bits (select 0) and a read-only copy of the address of the most recent blocked transfer (select 1). Clearing a kill bit reopens its window at once, with no further steps. Decoding among the downstream slaves happens outside this block.

The master raises `m_req` with address, direction and write data and holds them until `m_done` pulses. It drops `m_req` in the cycle where `m_done` is high. The slave side uses the same scheme: `s_req` stays high with stable outputs until the slave returns a one-cycle `s_ack`.

Top module: `range_gate`

## Requirements
- R1: After reset, all kill bits are clear, the captured fault address is zero, and `m_done`, `m_err`, `s_req` and `fault_pulse` are low.
- R2: A transfer whose address lies in a window with a clear kill bit is forwarded. `s_addr`, `s_we` and `s_wdata` equal the master's values, and `s_req` stays high with a stable address until `s_ack`, then falls. Read data from the slave comes back on `m_rdata` with `m_err` low.
- R3: A transfer to a window whose kill bit is set is not forwarded. `s_req` never rises for it, a write leaves the slave contents untouched, and the master sees `m_done` with `m_err` high and `m_rdata` equal to zero.
- R4: A transfer to an address inside no window is handled exactly as in R3. By default, window i covers base i*0x2000 with size 0x1000, so any address with bit 12 set is outside every window.
- R5: Every blocked transfer raises `fault_pulse` for exactly one cycle, in the same cycle as its error response. Forwarded transfers never raise it.
- R6: Register select 1 returns the address of the most recent blocked transfer, zero-extended. It changes only when a transfer is blocked.
- R7: Register select 0 holds the kill bits, with bit i belonging to window i. It reads back what was written, and clearing a bit makes that window usable again.
- R8: A kill-bit write takes effect for transfers accepted on the clock edge after the write edge. A transfer accepted on the same edge as the write is judged with the old bits.
- R9: A blocked transfer completes with `m_done` in the cycle after it is accepted. A forwarded transfer completes in the cycle after the edge where `s_ack` is sampled.
- R10: `m_done` is a one-cycle pulse. Register reads return data in the cycle after `cfg_rd` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_req | input | 1 | Master request, held until m_done |
| m_we | input | 1 | Master write enable |
| m_addr | input | AW | Master address |
| m_wdata | input | DW | Master write data |
| m_done | output | 1 | Transfer complete pulse |
| m_err | output | 1 | Error response, valid with m_done |
| m_rdata | output | DW | Read data, valid with m_done |
| s_req | output | 1 | Downstream request |
| s_we | output | 1 | Downstream write enable |
| s_addr | output | AW | Downstream address |
| s_wdata | output | DW | Downstream write data |
| s_ack | input | 1 | Downstream completion pulse |
| s_rdata | input | DW | Downstream read data, valid with s_ack |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_sel | input | 1 | Register select: 0 kill bits, 1 fault address |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Register read data |
| fault_pulse | output | 1 | One-cycle fault indication |

## Verification
The hardest case to reach is a kill-bit write and a new transfer landing on the same clock edge, and on adjacent edges. This is the only point where the order of register update and decode shows. Directed sequences drive the register strobe and `m_req` in the same cycle and in back-to-back cycles, so each edge case is hit exactly. Random traffic with occasional random kill masks then mixes forwarded, disabled and unmapped addresses under varying slave latency. Window edges (first and last byte, and the first byte past each end) are covered by direct cases.

// File: rtl/range_gate_pkg.sv
package range_gate_pkg;
  typedef enum logic [1:0] {
    GS_IDLE = 2'd0,
    GS_FWD  = 2'd1,
    GS_DONE = 2'd2
  } gate_state_t;

  localparam logic SEL_KILL  = 1'b0;
  localparam logic SEL_FAULT = 1'b1;
endpackage

// File: rtl/range_gate_match.sv
module range_gate_match #(
  parameter int NREG = 8,
  parameter int AW   = 16,
  parameter logic [NREG-1:0][AW-1:0] BASE = '0,
  parameter logic [NREG-1:0][AW:0]   SIZE = '0
) (
  input  logic [AW-1:0]   addr,
  input  logic [NREG-1:0] kill,
  output logic            permit,
  output logic            mapped
);
  logic [NREG-1:0] hit;
  logic [AW:0]     addr_x;

  assign addr_x = {1'b0, addr};

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_win
      localparam logic [AW:0] LO = {1'b0, BASE[g]};
      localparam logic [AW:0] HI = LO + SIZE[g];
      assign hit[g] = (addr_x >= LO) && (addr_x < HI);
    end
  endgenerate

  assign mapped = |hit;
  assign permit = |(hit & ~kill);
endmodule

// File: rtl/range_gate_regs.sv
module range_gate_regs
  import range_gate_pkg::*;
#(
  parameter int NREG = 8,
  parameter int AW   = 16,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_wr,
  input  logic            cfg_rd,
  input  logic            cfg_sel,
  input  logic [DW-1:0]   cfg_wdata,
  input  logic            fault_set,
  input  logic [AW-1:0]   fault_addr,
  output logic [NREG-1:0] kill,
  output logic [DW-1:0]   cfg_rdata
);
  logic [AW-1:0] fault_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      kill      <= '0;
      fault_q   <= '0;
      cfg_rdata <= '0;
    end else begin
      if (cfg_wr && cfg_sel == SEL_KILL)
        kill <= cfg_wdata[NREG-1:0];
      if (fault_set)
        fault_q <= fault_addr;
      if (cfg_rd)
        cfg_rdata <= (cfg_sel == SEL_FAULT) ? DW'(fault_q) : DW'(kill);
    end
  end
endmodule

// File: rtl/range_gate_ctl.sv
module range_gate_ctl
  import range_gate_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          m_req,
  input  logic          m_we,
  input  logic [AW-1:0] m_addr,
  input  logic [DW-1:0] m_wdata,
  input  logic          permit,
  input  logic          s_ack,
  input  logic [DW-1:0] s_rdata,
  output logic          m_done,
  output logic          m_err,
  output logic [DW-1:0] m_rdata,
  output logic          s_req,
  output logic          lat_we,
  output logic [AW-1:0] lat_addr,
  output logic [DW-1:0] lat_wdata,
  output logic          fault_pulse
);
  gate_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= GS_IDLE;
      m_done      <= 1'b0;
      m_err       <= 1'b0;
      m_rdata     <= '0;
      s_req       <= 1'b0;
      lat_we      <= 1'b0;
      lat_addr    <= '0;
      lat_wdata   <= '0;
      fault_pulse <= 1'b0;
    end else begin
      m_done      <= 1'b0;
      m_err       <= 1'b0;
      fault_pulse <= 1'b0;
      case (state)
        GS_IDLE: begin
          if (m_req) begin
            lat_we    <= m_we;
            lat_addr  <= m_addr;
            lat_wdata <= m_wdata;
            if (permit) begin
              s_req <= 1'b1;
              state <= GS_FWD;
            end else begin
              m_done      <= 1'b1;
              m_err       <= 1'b1;
              m_rdata     <= '0;
              fault_pulse <= 1'b1;
              state       <= GS_DONE;
            end
          end
        end
        GS_FWD: begin
          if (s_ack) begin
            s_req   <= 1'b0;
            m_done  <= 1'b1;
            m_rdata <= lat_we ? '0 : s_rdata;
            state   <= GS_DONE;
          end
        end
        default: state <= GS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/range_gate.sv
module range_gate
  import range_gate_pkg::*;
#(
  parameter int NREG = 8,
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter logic [NREG-1:0][AW-1:0] REGION_BASE = {
    16'hE000, 16'hC000, 16'hA000, 16'h8000,
    16'h6000, 16'h4000, 16'h2000, 16'h0000},
  parameter logic [NREG-1:0][AW:0] REGION_SIZE = {
    17'h01000, 17'h01000, 17'h01000, 17'h01000,
    17'h01000, 17'h01000, 17'h01000, 17'h01000}
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          m_req,
  input  logic          m_we,
  input  logic [AW-1:0] m_addr,
  input  logic [DW-1:0] m_wdata,
  output logic          m_done,
  output logic          m_err,
  output logic [DW-1:0] m_rdata,
  output logic          s_req,
  output logic          s_we,
  output logic [AW-1:0] s_addr,
  output logic [DW-1:0] s_wdata,
  input  logic          s_ack,
  input  logic [DW-1:0] s_rdata,
  input  logic          cfg_wr,
  input  logic          cfg_rd,
  input  logic          cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  output logic          fault_pulse
);
  logic [NREG-1:0] kill;
  logic            permit;
  logic            mapped;

  range_gate_match #(
    .NREG(NREG), .AW(AW), .BASE(REGION_BASE), .SIZE(REGION_SIZE)
  ) u_match (
    .addr   (m_addr),
    .kill   (kill),
    .permit (permit),
    .mapped (mapped)
  );

  range_gate_ctl #(.AW(AW), .DW(DW)) u_ctl (
    .clk         (clk),
    .rst         (rst),
    .m_req       (m_req),
    .m_we        (m_we),
    .m_addr      (m_addr),
    .m_wdata     (m_wdata),
    .permit      (permit),
    .s_ack       (s_ack),
    .s_rdata     (s_rdata),
    .m_done      (m_done),
    .m_err       (m_err),
    .m_rdata     (m_rdata),
    .s_req       (s_req),
    .lat_we      (s_we),
    .lat_addr    (s_addr),
    .lat_wdata   (s_wdata),
    .fault_pulse (fault_pulse)
  );

  range_gate_regs #(.NREG(NREG), .AW(AW), .DW(DW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .cfg_wr     (cfg_wr),
    .cfg_rd     (cfg_rd),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .fault_set  (fault_pulse),
    .fault_addr (s_addr),
    .kill       (kill),
    .cfg_rdata  (cfg_rdata)
  );

  logic unused_mapped;
  assign unused_mapped = mapped;
endmodule

// File: rtl/range_gate_chk.sv
module range_gate_chk #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          m_done,
  input logic          m_err,
  input logic [DW-1:0] m_rdata,
  input logic          s_req,
  input logic          s_ack,
  input logic [AW-1:0] s_addr,
  input logic          fault_pulse
);
  assert_err_zero_data_R3: assert property (@(posedge clk) disable iff (rst)
    (m_done && m_err) |-> (m_rdata == '0));

  assert_blocked_not_sent_R3: assert property (@(posedge clk) disable iff (rst)
    fault_pulse |-> !s_req);

  assert_fault_single_R5: assert property (@(posedge clk) disable iff (rst)
    fault_pulse |=> !fault_pulse);

  assert_fault_with_err_R5: assert property (@(posedge clk) disable iff (rst)
    fault_pulse |-> (m_done && m_err));

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (s_req && !s_ack) |=> (s_req && $stable(s_addr)));

  assert_req_release_R2: assert property (@(posedge clk) disable iff (rst)
    (s_req && s_ack) |=> !s_req);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    m_done |=> !m_done);
endmodule

bind range_gate range_gate_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .m_done      (m_done),
  .m_err       (m_err),
  .m_rdata     (m_rdata),
  .s_req       (s_req),
  .s_ack       (s_ack),
  .s_addr      (s_addr),
  .fault_pulse (fault_pulse)
);

// File: tb/range_gate_test.sv
`timescale 1ns/1ps
module range_gate_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        m_req = 1'b0, m_we = 1'b0;
  logic [15:0] m_addr = '0;
  logic [31:0] m_wdata = '0;
  logic        m_done, m_err;
  logic [31:0] m_rdata;
  logic        s_req, s_we;
  logic [15:0] s_addr;
  logic [31:0] s_wdata;
  logic        s_ack = 1'b0;
  logic [31:0] s_rdata = '0;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0, cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        fault_pulse;

  always #4 clk = ~clk;

  range_gate uut (
    .clk(clk), .rst(rst), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_done(m_done), .m_err(m_err), .m_rdata(m_rdata),
    .s_req(s_req), .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata),
    .s_ack(s_ack), .s_rdata(s_rdata), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .fault_pulse(fault_pulse)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done_flag = 0;
  logic [7:0] kill_m = '0;

  // downstream slave model
  logic [31:0] mem [256];
  int          fwd_count = 0;
  int          wcnt = 0;
  logic [15:0] last_addr = '0;
  logic        last_we = 1'b0;
  logic [31:0] last_wdata = '0;

  function automatic logic [7:0] idx_of(input logic [15:0] a);
    return {a[15:13], a[4:0]};
  endfunction

  function automatic bit in_window(input logic [15:0] a);
    return a[12] == 1'b0;
  endfunction

  function automatic bit allowed(input logic [15:0] a, input logic [7:0] k);
    return in_window(a) && !k[a[15:13]];
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hA5000000 ^ (i * 32'h01010101);
  end

  always @(posedge clk) begin
    #2;
    if (s_req && !s_ack) begin
      if (wcnt == 0) begin
        s_ack = 1'b1;
        s_rdata = mem[idx_of(s_addr)];
        last_addr = s_addr;
        last_we = s_we;
        last_wdata = s_wdata;
        if (s_we) mem[idx_of(s_addr)] = s_wdata;
        fwd_count++;
        wcnt = $urandom % 3;
      end else begin
        wcnt--;
      end
    end else begin
      s_ack = 1'b0;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      finish_run();
    end
  end

  task automatic xfer(input logic [15:0] a, input bit we, input logic [31:0] wd,
                      output bit err, output logic [31:0] rd, output int lat,
                      output int ack_lat, output bit saw_fault);
    @(negedge clk);
    m_req = 1'b1; m_we = we; m_addr = a; m_wdata = wd;
    lat = 0; ack_lat = -1; saw_fault = 0; err = 0; rd = '0;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      lat++;
      if (fault_pulse) saw_fault = 1;
      if (s_ack) ack_lat = lat;
      if (m_done) begin
        err = m_err; rd = m_rdata;
        m_req = 1'b0;
        return;
      end
    end
    m_req = 1'b0;
    chk("R9", "transfer timeout", 32'd64, 32'd0);
  endtask

  task automatic cfg_write(input bit sel, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input bit sel, output logic [31:0] d);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_sel = sel;
    @(negedge clk);
    d = cfg_rdata;
    cfg_rd = 1'b0;
  endtask

  task automatic run_check(input logic [15:0] a, input bit we, input logic [31:0] wd);
    bit err, sf; logic [31:0] rd, v, old; int lat, al, fc0; bit ok; string tag;
    ok  = allowed(a, kill_m);
    fc0 = fwd_count;
    old = mem[idx_of(a)];
    tag = ok ? "R2" : (in_window(a) ? "R3" : "R4");
    xfer(a, we, wd, err, rd, lat, al, sf);
    chk(tag, "m_err", 32'(err), 32'(!ok));
    if (ok) begin
      chk("R2", "forward count", fwd_count, fc0 + 1);
      chk("R2", "s_addr", 32'(last_addr), 32'(a));
      chk("R2", "s_we", 32'(last_we), 32'(we));
      if (we) chk("R2", "written data", mem[idx_of(a)], wd);
      else    chk("R2", "read data", rd, old);
      chk("R9", "forward done latency", lat, al + 1);
      chk("R5", "no fault on legal", 32'(sf), 32'd0);
    end else begin
      chk(tag, "zero read data", rd, 32'd0);
      chk(tag, "not forwarded", fwd_count, fc0);
      chk(tag, "slave untouched", mem[idx_of(a)], old);
      chk("R5", "fault pulse", 32'(sf), 32'd1);
      chk("R9", "blocked latency", lat, 32'd1);
      cfg_read(1'b1, v);
      chk("R6", "fault address", v, 32'(a));
    end
  endtask

  initial begin
    logic [31:0] v;
    bit err, sf; logic [31:0] rd; int lat, al;
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    // R1 reset state, sampled while reset is held
    chk("R1", "m_done", 32'(m_done), 32'd0);
    chk("R1", "m_err", 32'(m_err), 32'd0);
    chk("R1", "s_req", 32'(s_req), 32'd0);
    chk("R1", "fault_pulse", 32'(fault_pulse), 32'd0);
    rst = 1'b0;
    cfg_read(1'b0, v); chk("R1", "kill bits", v, 32'd0);
    cfg_read(1'b1, v); chk("R1", "fault address", v, 32'd0);

    // R2 legal read and write
    run_check(16'h0010, 1'b0, 32'h0);
    run_check(16'h6008, 1'b1, 32'hCAFE0001);
    run_check(16'h6008, 1'b0, 32'h0);

    // R4 unmapped plus window edges
    run_check(16'h1234, 1'b0, 32'h0);
    run_check(16'hE000, 1'b0, 32'h0);
    run_check(16'hEFFF, 1'b1, 32'h12345678);
    run_check(16'hF000, 1'b1, 32'hDEAD0000);
    run_check(16'h0FFF, 1'b0, 32'h0);
    run_check(16'h1000, 1'b0, 32'h0);

    // R7 kill bit write and readback; R3 disabled window
    kill_m = 8'h08;
    cfg_write(1'b0, 32'h08);
    cfg_read(1'b0, v); chk("R7", "kill readback", v, 32'h08);
    run_check(16'h6010, 1'b1, 32'hBAD00001);
    run_check(16'h6014, 1'b0, 32'h0);
    // R6: legal transfer leaves fault address alone
    run_check(16'h2004, 1'b0, 32'h0);
    cfg_read(1'b1, v); chk("R6", "fault address kept", v, 32'h6014);

    // R8: write and transfer on the same edge use the old kill bits
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_wdata = 32'h00;
    m_req = 1'b1; m_we = 1'b0; m_addr = 16'h6020;
    @(negedge clk);
    cfg_wr = 1'b0;
    chk("R8", "same-edge uses old bits: done", 32'(m_done), 32'd1);
    chk("R8", "same-edge uses old bits: err", 32'(m_err), 32'd1);
    m_req = 1'b0;
    kill_m = 8'h00;
    // R7 clearing restores access
    run_check(16'h6020, 1'b0, 32'h0);

    // R8: transfer on the edge right after the write sees the new bits
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_wdata = 32'h01;
    @(negedge clk);
    cfg_wr = 1'b0;
    m_req = 1'b1; m_we = 1'b0; m_addr = 16'h0004;
    @(negedge clk);
    chk("R8", "next-edge uses new bits: err", 32'(m_done && m_err), 32'd1);
    m_req = 1'b0;
    @(negedge clk);
    chk("R10", "done one cycle", 32'(m_done), 32'd0);
    kill_m = 8'h01;

    // R10 register read latency: data appears one cycle after strobe
    @(negedge clk);
    cfg_rd = 1'b1; cfg_sel = 1'b0;
    @(negedge clk);
    cfg_rd = 1'b0;
    chk("R10", "read data next cycle", cfg_rdata, 32'h01);

    // random traffic
    for (int i = 0; i < 400; i++) begin
      if ($urandom % 8 == 0) begin
        kill_m = 8'($urandom);
        cfg_write(1'b0, 32'(kill_m));
      end
      run_check(16'($urandom), 1'($urandom), $urandom);
    end
    cfg_read(1'b0, v); chk("R7", "final kill readback", v, 32'(kill_m));

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule